// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block is the architectural register file of a processor core that runs in several operating modes. Software sees sixteen 32-bit logical registers, numbered 0 to 15. Number 13 is the stack pointer, 14 is the link register and 15 is the program counter. Behind these logical numbers the block keeps more physical storage than sixteen words. The current mode decides which physical copy a logical number reaches for a handful of registers. Because of this, an exception handler finds its own stack pointer and link register already in place, with no save and restore needed.

The core reads two operands through two combinational read ports and writes one result per cycle. All three ports use a 4-bit logical index and the same 5-bit mode input. The fast-interrupt mode has a private copy of logical registers 8 to 14. The other exception modes have private copies of 13 and 14 only. Each exception mode also owns one saved status word, which has its own read and write port and is addressed by the current mode alone. User mode, system mode and unrecognised mode codes all share the unbanked view and have no saved status word.

Top module: `bank_rf`

## Requirements
- R1: While reset is asserted, every read port returns zero. After reset is released, every physical register and every saved status word reads zero until it is written.
- R2: Logical registers 0 to 7 and 15 have a single physical copy. A value written to one of them in any mode is read back unchanged in every other mode.
- R3: In fast-interrupt mode (mode code 10001), logical registers 8 to 14 reach private storage. A write to them in that mode is invisible from user mode (10000), and a user-mode write is invisible from fast-interrupt mode.
- R4: In IRQ (10010), supervisor (10011), monitor (10110), abort (10111) and undefined (11011) modes, logical 13 and 14 reach storage private to that mode. Logical 8 to 12 reach the same copies that user mode sees.
- R5: System mode (11111) and every mode code not listed in R3 or R4 use the same register view as user mode.
- R6: The private copies of logical 13 and 14 in the six exception modes are all distinct. A write in one exception mode does not change the value read in any other mode.
- R7: Each of the six exception modes has its own saved status word. It is written through the status write port and read through the status read port while that mode is current.
- R8: In user mode, system mode or an unlisted mode code, the status read port returns zero and a status write changes no saved status word.
- R9: A write takes effect at the clock edge. A read of the written register in the same cycle returns the old value, and the next cycle returns the new value.
- R10: The two read ports work independently. When both ports address the same logical register in the same mode, they return the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| mode | input | 5 | Current processor mode code |
| rd_a_idx | input | 4 | Logical index for read port A |
| rd_a_data | output | 32 | Read port A data, combinational |
| rd_b_idx | input | 4 | Logical index for read port B |
| rd_b_data | output | 32 | Read port B data, combinational |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 4 | Logical index for the write |
| wr_data | input | 32 | Write data |
| sr_rd_data | output | 32 | Saved status word of the current mode, or zero if the mode has none |
| sr_wr_en | input | 1 | Saved status write enable |
| sr_wr_data | input | 32 | Saved status write data |

## Verification
The assertions assume that mode, the indices and the enables are driven to known values on every clock edge, and that no write is issued in the first cycles after reset release, while the internal reset is still asserted. They also assume that a write and the read checked against it in the next cycle use the same mode code. The stimulus changes inputs only just after a rising edge. It holds every enable low through reset and the settling cycles after it, and it makes each write-then-read pair inside a single mode. It switches modes only between such pairs.

// File: rtl/bank_rf_pkg.sv
package bank_rf_pkg;

  // Register banks that own private storage
  typedef enum logic [2:0] {
    BK_USR = 3'd0,
    BK_FIQ = 3'd1,
    BK_IRQ = 3'd2,
    BK_SVC = 3'd3,
    BK_MON = 3'd4,
    BK_ABT = 3'd5,
    BK_UND = 3'd6
  } bank_e;

  localparam int NUM_BANKS = 7;
  localparam int NUM_SR    = NUM_BANKS - 1;
  localparam int SR_SEL_W  = $clog2(NUM_SR);

  // Physical layout: shared low words, program counter, two upper-range copies,
  // then a stack/link pair per bank.
  localparam int P_PC      = 8;
  localparam int P_USR_HI  = 9;
  localparam int P_FIQ_HI  = 14;
  localparam int P_SP_BASE = 19;
  localparam int PHYS_N    = P_SP_BASE + 2 * NUM_BANKS;
  localparam int PHYS_W    = $clog2(PHYS_N);

  // Mode codes
  localparam logic [4:0] MODE_USR = 5'b10000;
  localparam logic [4:0] MODE_FIQ = 5'b10001;
  localparam logic [4:0] MODE_IRQ = 5'b10010;
  localparam logic [4:0] MODE_SVC = 5'b10011;
  localparam logic [4:0] MODE_MON = 5'b10110;
  localparam logic [4:0] MODE_ABT = 5'b10111;
  localparam logic [4:0] MODE_UND = 5'b11011;
  localparam logic [4:0] MODE_SYS = 5'b11111;

endpackage

// File: rtl/bank_rf_mode_dec.sv
module bank_rf_mode_dec
  import bank_rf_pkg::*;
(
  input  logic [4:0]          mode,
  output bank_e               bank,
  output logic                has_sr,
  output logic [SR_SEL_W-1:0] sr_sel
);

  always_comb begin
    case (mode)
      MODE_FIQ: bank = BK_FIQ;
      MODE_IRQ: bank = BK_IRQ;
      MODE_SVC: bank = BK_SVC;
      MODE_MON: bank = BK_MON;
      MODE_ABT: bank = BK_ABT;
      MODE_UND: bank = BK_UND;
      default:  bank = BK_USR;
    endcase
  end

  always_comb begin
    has_sr = (bank != BK_USR);
    sr_sel = has_sr ? SR_SEL_W'(int'(bank) - 1) : '0;
  end

endmodule

// File: rtl/bank_rf_map.sv
module bank_rf_map
  import bank_rf_pkg::*;
(
  input  logic [3:0]        idx,
  input  bank_e             bank,
  output logic [PHYS_W-1:0] phys
);

  always_comb begin
    if (idx == 4'd15) begin
      phys = PHYS_W'(P_PC);
    end else if (idx < 4'd8) begin
      phys = PHYS_W'(idx);
    end else if (idx < 4'd13) begin
      if (bank == BK_FIQ) phys = PHYS_W'(P_FIQ_HI + int'(idx) - 8);
      else                phys = PHYS_W'(P_USR_HI + int'(idx) - 8);
    end else begin
      phys = PHYS_W'(P_SP_BASE + 2 * int'(bank) + int'(idx) - 13);
    end
  end

endmodule

// File: rtl/bank_rf_store.sv
module bank_rf_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 33,
  parameter int AW     = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     rd_a_ph,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [AW-1:0]     rd_b_ph,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_ph,
  input  logic [DATA_W-1:0] wr_data
);

  localparam int SLOTS = 2 ** AW;

  logic [DATA_W-1:0] word_q [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    if (g < DEPTH) begin : g_live
      logic              hit;
      logic [DATA_W-1:0] q;
      logic [DATA_W-1:0] d;

      always_comb begin
        hit = wr_en && (wr_ph == AW'(g));
        d   = hit ? wr_data : q;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
      end

      assign word_q[g] = q;
    end else begin : g_tie
      assign word_q[g] = '0;
    end
  end

  assign rd_a_data = word_q[rd_a_ph];
  assign rd_b_data = word_q[rd_b_ph];

endmodule

// File: rtl/bank_rf_status.sv
module bank_rf_status #(
  parameter int DATA_W = 32,
  parameter int N      = 6,
  parameter int SW     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              has_sr,
  input  logic [SW-1:0]     sel,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);

  localparam int SLOTS = 2 ** SW;

  logic [DATA_W-1:0] sr_q [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_sr
    if (g < N) begin : g_live
      logic              hit;
      logic [DATA_W-1:0] q;
      logic [DATA_W-1:0] d;

      always_comb begin
        hit = wr_en && has_sr && (sel == SW'(g));
        d   = hit ? wr_data : q;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
      end

      assign sr_q[g] = q;
    end else begin : g_tie
      assign sr_q[g] = '0;
    end
  end

  assign rd_data = has_sr ? sr_q[sel] : '0;

endmodule

// File: rtl/bank_rf.sv
module bank_rf
  import bank_rf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [4:0]        mode,
  input  logic [3:0]        rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [3:0]        rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [3:0]        wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] sr_rd_data,
  input  logic              sr_wr_en,
  input  logic [DATA_W-1:0] sr_wr_data
);

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic [1:0] rst_sync_d;
  logic       rst_int_n;

  always_comb rst_sync_d = {rst_sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= rst_sync_d;
  end

  assign rst_int_n = rst_sync_q[1];

  // Mode decode
  bank_e               bank;
  logic                has_sr;
  logic [SR_SEL_W-1:0] sr_sel;

  bank_rf_mode_dec u_dec (
    .mode   (mode),
    .bank   (bank),
    .has_sr (has_sr),
    .sr_sel (sr_sel)
  );

  // One mapper per port
  logic [PHYS_W-1:0] ph_a, ph_b, ph_w;

  bank_rf_map u_map_a (.idx(rd_a_idx), .bank(bank), .phys(ph_a));
  bank_rf_map u_map_b (.idx(rd_b_idx), .bank(bank), .phys(ph_b));
  bank_rf_map u_map_w (.idx(wr_idx),   .bank(bank), .phys(ph_w));

  bank_rf_store #(
    .DATA_W (DATA_W),
    .DEPTH  (PHYS_N),
    .AW     (PHYS_W)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .rd_a_ph   (ph_a),
    .rd_a_data (rd_a_data),
    .rd_b_ph   (ph_b),
    .rd_b_data (rd_b_data),
    .wr_en     (wr_en),
    .wr_ph     (ph_w),
    .wr_data   (wr_data)
  );

  bank_rf_status #(
    .DATA_W (DATA_W),
    .N      (NUM_SR),
    .SW     (SR_SEL_W)
  ) u_status (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .has_sr  (has_sr),
    .sel     (sr_sel),
    .wr_en   (sr_wr_en),
    .wr_data (sr_wr_data),
    .rd_data (sr_rd_data)
  );

endmodule

// File: rtl/bank_rf_chk.sv
module bank_rf_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [4:0]        mode,
  input logic [3:0]        rd_a_idx,
  input logic [DATA_W-1:0] rd_a_data,
  input logic [3:0]        rd_b_idx,
  input logic [DATA_W-1:0] rd_b_data,
  input logic              wr_en,
  input logic [3:0]        wr_idx,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] sr_rd_data
);

  // Settling counter: writes count only once the internal reset is released
  logic [1:0] settle_q;
  logic       ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               settle_q <= '0;
    else if (settle_q != 2'd3) settle_q <= settle_q + 2'd1;
  end

  assign ready = (settle_q == 2'd3);

  function automatic logic owns_status(input logic [4:0] m);
    case (m)
      5'b10001, 5'b10010, 5'b10011, 5'b10110, 5'b10111, 5'b11011: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // R1
  p_reset_zero_r1: assert property (@(posedge clk)
    !rst_n |-> (rd_a_data == '0 && rd_b_data == '0 && sr_rd_data == '0));

  // R2
  p_shared_vis_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && $past(wr_en) && ($past(wr_idx) < 4'd8 || $past(wr_idx) == 4'd15)
      && rd_a_idx == $past(wr_idx))
    |-> rd_a_data == $past(wr_data));

  // R8
  p_sr_blank_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !owns_status(mode) |-> sr_rd_data == '0);

  // R9
  p_next_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && $past(wr_en) && $past(mode) == mode && rd_b_idx == $past(wr_idx))
    |-> rd_b_data == $past(wr_data));

  // R10
  p_ports_agree_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_a_idx == rd_b_idx |-> rd_a_data == rd_b_data);

endmodule

bind bank_rf bank_rf_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/bank_rf_tb_top.sv
`timescale 1ns/1ps
module bank_rf_tb_top;

  localparam logic [4:0] M_USR = 5'b10000;
  localparam logic [4:0] M_FIQ = 5'b10001;
  localparam logic [4:0] M_IRQ = 5'b10010;
  localparam logic [4:0] M_SVC = 5'b10011;
  localparam logic [4:0] M_MON = 5'b10110;
  localparam logic [4:0] M_ABT = 5'b10111;
  localparam logic [4:0] M_UND = 5'b11011;
  localparam logic [4:0] M_SYS = 5'b11111;
  localparam logic [4:0] M_BAD = 5'b10100;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  mode;
  logic [3:0]  rd_a_idx, rd_b_idx, wr_idx;
  logic [31:0] rd_a_data, rd_b_data, wr_data, sr_rd_data, sr_wr_data;
  logic        wr_en, sr_wr_en;

  always #2.5 clk = ~clk;

  bank_rf dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode),
    .rd_a_idx   (rd_a_idx),
    .rd_a_data  (rd_a_data),
    .rd_b_idx   (rd_b_idx),
    .rd_b_data  (rd_b_data),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_data    (wr_data),
    .sr_rd_data (sr_rd_data),
    .sr_wr_en   (sr_wr_en),
    .sr_wr_data (sr_wr_data)
  );

  typedef struct {
    int          cyc;
    int          port;   // 0 = A, 1 = B, 2 = status
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int    cyc   = 0;
  int    total = 0;
  int    bad   = 0;
  bit    ended = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compares queued expectations in the middle of their cycle
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].cyc == cyc) begin
      item_t it;
      logic [31:0] act;
      it  = q.pop_front();
      act = (it.port == 0) ? rd_a_data : (it.port == 1) ? rd_b_data : sr_rd_data;
      total++;
      if (act !== it.exp) begin
        bad++;
        $display("FAIL %s port=%0d act=%h exp=%h", it.tag, it.port, act, it.exp);
      end
    end
  end

  task automatic push(input int port, input logic [31:0] v, input string tag);
    item_t it;
    it.cyc = cyc; it.port = port; it.exp = v; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic drv(input logic [4:0] m, input logic [3:0] ia, input logic [3:0] ib,
                     input logic we, input logic [3:0] wi, input logic [31:0] wd,
                     input logic swe, input logic [31:0] swd);
    @(posedge clk); #1;
    mode = m; rd_a_idx = ia; rd_b_idx = ib;
    wr_en = we; wr_idx = wi; wr_data = wd;
    sr_wr_en = swe; sr_wr_data = swd;
  endtask

  task automatic wr(input logic [4:0] m, input logic [3:0] i, input logic [31:0] v);
    drv(m, i, i, 1'b1, i, v, 1'b0, '0);
  endtask

  task automatic rd(input logic [4:0] m, input logic [3:0] ia, input logic [3:0] ib);
    drv(m, ia, ib, 1'b0, '0, '0, 1'b0, '0);
  endtask

  task automatic swr(input logic [4:0] m, input logic [31:0] v);
    drv(m, 4'd0, 4'd0, 1'b0, '0, '0, 1'b1, v);
  endtask

  initial begin
    rst_n = 1'b0;
    mode = M_USR; rd_a_idx = 4'd13; rd_b_idx = 4'd15;
    wr_en = 1'b0; wr_idx = '0; wr_data = '0; sr_wr_en = 1'b0; sr_wr_data = '0;
    @(posedge clk); #1;
    push(0, 32'h0, "R1 reset A"); push(1, 32'h0, "R1 reset B");
    mode = M_SVC; #1; push(2, 32'h0, "R1 reset status");
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) rd(M_USR, 4'd0, 4'd15);
    rd(M_FIQ, 4'd13, 4'd8); push(0, 32'h0, "R1 fiq sp"); push(1, 32'h0, "R1 fiq r8");
    rd(M_UND, 4'd14, 4'd12); push(0, 32'h0, "R1 und lr"); push(2, 32'h0, "R1 und sr");

    // User-mode writes; same-cycle read returns old value
    wr(M_USR, 4'd0, 32'hA0);  push(0, 32'h0, "R9 old value");
    rd(M_USR, 4'd0, 4'd0);    push(0, 32'hA0, "R9 new value");
    wr(M_USR, 4'd8, 32'h88);
    wr(M_USR, 4'd13, 32'hD0);
    wr(M_USR, 4'd14, 32'hE0);
    wr(M_USR, 4'd15, 32'hF0);
    wr(M_USR, 4'd7, 32'h77);

    // Fast-interrupt view
    rd(M_FIQ, 4'd0, 4'd15); push(0, 32'hA0, "R2 r0 in fiq"); push(1, 32'hF0, "R2 pc in fiq");
    rd(M_FIQ, 4'd8, 4'd13); push(0, 32'h0, "R3 fiq r8 private"); push(1, 32'h0, "R3 fiq sp private");
    wr(M_FIQ, 4'd8, 32'h1188);
    wr(M_FIQ, 4'd13, 32'h11D0);
    rd(M_USR, 4'd8, 4'd13); push(0, 32'h88, "R3 usr r8 kept"); push(1, 32'hD0, "R3 usr sp kept");
    rd(M_FIQ, 4'd8, 4'd13); push(0, 32'h1188, "R3 fiq r8"); push(1, 32'h11D0, "R3 fiq sp");

    // Other exception modes
    rd(M_IRQ, 4'd8, 4'd13); push(0, 32'h88, "R4 irq r8 shared"); push(1, 32'h0, "R4 irq sp private");
    rd(M_IRQ, 4'd7, 4'd15); push(0, 32'h77, "R2 r7 in irq"); push(1, 32'hF0, "R2 pc in irq");
    wr(M_IRQ, 4'd13, 32'h12D0);
    wr(M_IRQ, 4'd14, 32'h12E0);
    rd(M_SVC, 4'd13, 4'd14); push(0, 32'h0, "R6 svc sp"); push(1, 32'h0, "R6 svc lr");
    wr(M_SVC, 4'd13, 32'h13D0);
    wr(M_ABT, 4'd13, 32'h17D0);
    wr(M_UND, 4'd13, 32'h1BD0);
    wr(M_MON, 4'd13, 32'h16D0);
    wr(M_IRQ, 4'd9, 32'h99);
    rd(M_IRQ, 4'd13, 4'd14); push(0, 32'h12D0, "R6 irq sp"); push(1, 32'h12E0, "R6 irq lr");
    rd(M_SVC, 4'd13, 4'd9);  push(0, 32'h13D0, "R6 svc sp"); push(1, 32'h99, "R4 svc r9 shared");
    rd(M_ABT, 4'd13, 4'd14); push(0, 32'h17D0, "R6 abt sp"); push(1, 32'h0, "R6 abt lr");
    rd(M_UND, 4'd13, 4'd13); push(0, 32'h1BD0, "R6 und sp"); push(1, 32'h1BD0, "R10 same index");
    rd(M_MON, 4'd13, 4'd8);  push(0, 32'h16D0, "R6 mon sp"); push(1, 32'h88, "R4 mon r8 shared");
    rd(M_FIQ, 4'd13, 4'd9);  push(0, 32'h11D0, "R6 fiq sp kept"); push(1, 32'h0, "R3 fiq r9 private");
    rd(M_USR, 4'd13, 4'd14); push(0, 32'hD0, "R6 usr sp kept"); push(1, 32'hE0, "R6 usr lr kept");

    // System and unlisted codes share the user view
    rd(M_SYS, 4'd13, 4'd8); push(0, 32'hD0, "R5 sys sp"); push(1, 32'h88, "R5 sys r8");
    rd(M_BAD, 4'd14, 4'd9); push(0, 32'hE0, "R5 bad code lr"); push(1, 32'h99, "R5 bad code r9");
    wr(M_SYS, 4'd12, 32'hC0);
    rd(M_USR, 4'd12, 4'd0); push(0, 32'hC0, "R5 sys write seen in usr"); push(1, 32'hA0, "R10 port b");

    // Saved status words
    swr(M_FIQ, 32'hF1); push(2, 32'h0, "R9 status old value");
    swr(M_IRQ, 32'hF2);
    swr(M_SVC, 32'hF3);
    swr(M_MON, 32'hF6);
    swr(M_ABT, 32'hF7);
    swr(M_UND, 32'hFB);
    rd(M_FIQ, 0, 0); push(2, 32'hF1, "R7 fiq status");
    rd(M_IRQ, 0, 0); push(2, 32'hF2, "R7 irq status");
    rd(M_USR, 0, 0); push(2, 32'h0, "R8 usr status zero");
    swr(M_USR, 32'hBAD);
    swr(M_SYS, 32'hBAD1);
    swr(M_BAD, 32'hBAD2);
    rd(M_SYS, 0, 0); push(2, 32'h0, "R8 sys status zero");
    rd(M_SVC, 0, 0); push(2, 32'hF3, "R8 svc status untouched");
    rd(M_MON, 0, 0); push(2, 32'hF6, "R8 mon status untouched");
    rd(M_ABT, 0, 0); push(2, 32'hF7, "R8 abt status untouched");
    rd(M_UND, 0, 0); push(2, 32'hFB, "R8 und status untouched");
    rd(M_FIQ, 0, 0); push(2, 32'hF1, "R8 fiq status untouched");
    rd(M_IRQ, 0, 0); push(2, 32'hF2, "R8 irq status untouched");

    // Overwrite with same-cycle read
    wr(M_FIQ, 4'd8, 32'h2288); push(0, 32'h1188, "R9 fiq old value");
    rd(M_FIQ, 4'd8, 4'd0);     push(0, 32'h2288, "R9 fiq new value"); push(1, 32'hA0, "R10 port b r0");
    rd(M_USR, 4'd8, 4'd8);     push(0, 32'h88, "R3 usr r8 after fiq write");

    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    if (!ended) begin
      ended = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      total++; bad++;
      $display("FAIL watchdog expired act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule